// File: doc/BRIEF.md
# Privilege-Split Direct-Mapped Translation Buffer

This block keeps logical-to-physical page translations that a table walker has already resolved, so a repeated access to the same logical page gets its physical page at once and skips the walk. The entry array is split in two by privilege: the mode bit selects the user half or the supervisor half. Inside each half the buffer is direct-mapped, so a logical page has exactly one slot it can occupy.

The lookup path is combinational. It takes a logical page number, the mode bit and a lookup strobe, and returns hit, the physical page and a walk request on a miss. The walker writes finished translations through the fill port. Software can purge one slot or the whole buffer. A write strobe to either root pointer also flushes the whole buffer, with no separate purge command.

Top module: `priv_tlb`

## Requirements
- R1: After reset every slot is invalid, and every lookup misses.
- R2: The slot index is {mode, lpn[IDX_W-1:0]} (mode 1 = supervisor), and the stored tag is lpn[LPN_W-1:IDX_W]. A fill replaces whatever page the same slot held before.
- R3: lk_hit_o is high only when lk_valid_i is high, the slot is valid and the stored tag equals the lookup tag. On a hit, lk_ppn_o equals the physical page most recently filled into that slot.
- R4: The user and supervisor halves are independent. A page filled in one mode does not hit in the other mode.
- R5: walk_req_o equals lk_valid_i and not lk_hit_o. With lk_valid_i low, both outputs are low.
- R6: A fill takes effect at the clock edge. A lookup in the same cycle sees the old contents, and the new entry hits from the next cycle on.
- R7: purge_all_i invalidates every slot at one edge. A lookup in the cycle where it is asserted misses.
- R8: root_user_wr_i or root_super_wr_i acts exactly as purge_all_i.
- R9: purge_one_i invalidates the slot addressed by purge_super_i and purge_lpn_i, whatever tag it holds, and leaves every other slot unchanged.
- R10: When a selective purge and a fill address the same slot in one cycle, the slot ends invalid. A fill to a different slot still lands.
- R11: A whole-buffer flush (R7, R8) discards a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_super_i | input | 1 | Lookup mode, 1 = supervisor |
| lk_lpn_i | input | LPN_W | Lookup logical page number |
| lk_hit_o | output | 1 | Translation present |
| lk_ppn_o | output | PPN_W | Physical page, valid on hit |
| walk_req_o | output | 1 | Miss, table walk needed |
| fill_en_i | input | 1 | Write a translation |
| fill_super_i | input | 1 | Fill mode |
| fill_lpn_i | input | LPN_W | Fill logical page |
| fill_ppn_i | input | PPN_W | Fill physical page |
| purge_all_i | input | 1 | Invalidate all slots |
| purge_one_i | input | 1 | Invalidate one slot |
| purge_super_i | input | 1 | Selective purge mode |
| purge_lpn_i | input | LPN_W | Selective purge page |
| root_user_wr_i | input | 1 | User root pointer written |
| root_super_wr_i | input | 1 | Supervisor root pointer written |

## Verification
The bench builds the block with LPN_W=8, IDX_W=4 and PPN_W=12, which gives 16 slots per mode and only 16 distinct tags. Random pages drawn from that small space collide in their slots often. This brings tag replacement, cross-mode separation and purge/fill collisions on the same slot within reach in a few thousand cycles. Directed cycles place fills, purges and root writes in the same cycle as a lookup to check the ordering rules.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef enum logic {MODE_USER = 1'b0, MODE_SUPER = 1'b1} priv_e;
endpackage

// File: rtl/tlb_slot_index.sv
`timescale 1ns/1ps
module tlb_slot_index #(
  parameter int LPN_W = 20,
  parameter int IDX_W = 10
) (
  input  logic [LPN_W-1:0] lpn_i,
  input  logic             super_i,
  output logic [IDX_W:0]   slot_o
);
  import tlb_pkg::*;
  priv_e mode;
  assign mode   = priv_e'(super_i);
  // mode bit selects the half, low page bits select the slot
  assign slot_o = {mode == MODE_SUPER, lpn_i[IDX_W-1:0]};
endmodule

// File: rtl/tlb_valid_bits.sv
`timescale 1ns/1ps
module tlb_valid_bits #(
  parameter int SLOT_W = 11,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              set_en_i,
  input  logic [SLOT_W-1:0] set_idx_i,
  input  logic              kill_en_i,
  input  logic [SLOT_W-1:0] kill_idx_i,
  output logic [SLOTS-1:0]  valid_o
);
  logic [SLOTS-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else begin
      if (set_en_i)  valid_q[set_idx_i]  <= 1'b1;
      if (kill_en_i) valid_q[kill_idx_i] <= 1'b0; // purge wins on same slot
    end
  end

  assign valid_o = valid_q;

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
  assert_kill_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_en_i && !flush_i |=> !valid_q[$past(kill_idx_i)]);
  assert_fill_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i && !flush_i && !(kill_en_i && kill_idx_i == set_idx_i)
    |=> valid_q[$past(set_idx_i)]);
  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i && !set_en_i && !kill_en_i |=> valid_q == $past(valid_q));
endmodule

// File: rtl/tlb_entry_store.sv
`timescale 1ns/1ps
module tlb_entry_store #(
  parameter int SLOT_W = 11,
  parameter int TAG_W  = 10,
  parameter int PPN_W  = 20,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] widx_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [PPN_W-1:0]  wppn_i,
  input  logic [SLOT_W-1:0] ridx_i,
  output logic [TAG_W-1:0]  rtag_o,
  output logic [PPN_W-1:0]  rppn_o
);
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [PPN_W-1:0] ppn_q [SLOTS];

  // payload needs no reset, valid bits gate it
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[widx_i] <= wtag_i;
      ppn_q[widx_i] <= wppn_i;
    end
  end

  assign rtag_o = tag_q[ridx_i];
  assign rppn_o = ppn_q[ridx_i];

  assert_store_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ppn_q[$past(widx_i)] == $past(wppn_i) && tag_q[$past(widx_i)] == $past(wtag_i));
endmodule

// File: rtl/priv_tlb.sv
`timescale 1ns/1ps
module priv_tlb #(
  parameter int LPN_W = 20,
  parameter int IDX_W = 10,
  parameter int PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic             lk_super_i,
  input  logic [LPN_W-1:0] lk_lpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic             walk_req_o,
  input  logic             fill_en_i,
  input  logic             fill_super_i,
  input  logic [LPN_W-1:0] fill_lpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             purge_all_i,
  input  logic             purge_one_i,
  input  logic             purge_super_i,
  input  logic [LPN_W-1:0] purge_lpn_i,
  input  logic             root_user_wr_i,
  input  logic             root_super_wr_i
);
  localparam int SLOT_W = IDX_W + 1;
  localparam int TAG_W  = LPN_W - IDX_W;
  localparam int SLOTS  = 1 << SLOT_W;

  logic [SLOT_W-1:0] lk_slot, fill_slot, purge_slot;
  logic [TAG_W-1:0]  rd_tag;
  logic [PPN_W-1:0]  rd_ppn;
  logic [SLOTS-1:0]  valid;
  logic              flush;
  logic              unused_purge_tag;

  assign flush            = purge_all_i | root_user_wr_i | root_super_wr_i;
  assign unused_purge_tag = ^purge_lpn_i[LPN_W-1:IDX_W];

  tlb_slot_index #(.LPN_W(LPN_W), .IDX_W(IDX_W)) i_lk_idx (
    .lpn_i(lk_lpn_i), .super_i(lk_super_i), .slot_o(lk_slot));
  tlb_slot_index #(.LPN_W(LPN_W), .IDX_W(IDX_W)) i_fill_idx (
    .lpn_i(fill_lpn_i), .super_i(fill_super_i), .slot_o(fill_slot));
  tlb_slot_index #(.LPN_W(LPN_W), .IDX_W(IDX_W)) i_purge_idx (
    .lpn_i(purge_lpn_i), .super_i(purge_super_i), .slot_o(purge_slot));

  tlb_valid_bits #(.SLOT_W(SLOT_W)) i_valid (
    .clk_i, .rst_ni,
    .flush_i   (flush),
    .set_en_i  (fill_en_i),
    .set_idx_i (fill_slot),
    .kill_en_i (purge_one_i),
    .kill_idx_i(purge_slot),
    .valid_o   (valid));

  tlb_entry_store #(.SLOT_W(SLOT_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) i_store (
    .clk_i, .rst_ni,
    .we_i  (fill_en_i),
    .widx_i(fill_slot),
    .wtag_i(fill_lpn_i[LPN_W-1:IDX_W]),
    .wppn_i(fill_ppn_i),
    .ridx_i(lk_slot),
    .rtag_o(rd_tag),
    .rppn_o(rd_ppn));

  // a flush in flight hides every entry
  assign lk_hit_o   = lk_valid_i && !flush && valid[lk_slot] &&
                      (rd_tag == lk_lpn_i[LPN_W-1:IDX_W]);
  assign lk_ppn_o   = rd_ppn;
  assign walk_req_o = lk_valid_i && !lk_hit_o;

  assert_hit_excl_walk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && walk_req_o));
  assert_flush_then_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush && !fill_en_i |=> !lk_hit_o);
endmodule

// File: tb/test_priv_tlb.sv
`timescale 1ns/1ps
module test_priv_tlb;
  localparam int LPN_W = 8, IDX_W = 4, PPN_W = 12;
  localparam int SLOTS = 2 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_super = 0, fill_en = 0, fill_super = 0;
  logic purge_all = 0, purge_one = 0, purge_super = 0, ru = 0, rs = 0;
  logic [LPN_W-1:0] lk_lpn = '0, fill_lpn = '0, purge_lpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic hit, walk;
  logic [PPN_W-1:0] ppn;

  int checks = 0, fails = 0;
  bit m_valid [SLOTS];
  logic [LPN_W-IDX_W-1:0] m_tag [SLOTS];
  logic [PPN_W-1:0] m_ppn [SLOTS];

  always #4 clk = ~clk;

  priv_tlb #(.LPN_W(LPN_W), .IDX_W(IDX_W), .PPN_W(PPN_W)) i_priv_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_super_i(lk_super), .lk_lpn_i(lk_lpn),
    .lk_hit_o(hit), .lk_ppn_o(ppn), .walk_req_o(walk),
    .fill_en_i(fill_en), .fill_super_i(fill_super), .fill_lpn_i(fill_lpn), .fill_ppn_i(fill_ppn),
    .purge_all_i(purge_all), .purge_one_i(purge_one), .purge_super_i(purge_super),
    .purge_lpn_i(purge_lpn), .root_user_wr_i(ru), .root_super_wr_i(rs));

  function automatic int slot_of(bit sup, logic [LPN_W-1:0] lpn);
    return int'({sup, lpn[IDX_W-1:0]});
  endfunction

  function automatic bit exp_hit(bit lv, bit sup, logic [LPN_W-1:0] lpn, bit fl);
    int s = slot_of(sup, lpn);
    return lv && !fl && m_valid[s] && m_tag[s] == lpn[LPN_W-1:IDX_W];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, update model
  task automatic cyc(bit lv, bit lsup, logic [LPN_W-1:0] llpn,
                     bit fe, bit fsup, logic [LPN_W-1:0] flpn, logic [PPN_W-1:0] fppn,
                     bit pa, bit po, bit psup, logic [LPN_W-1:0] plpn,
                     bit rwu, bit rws, string req);
    bit fl, eh;
    @(negedge clk);
    lk_valid = lv; lk_super = lsup; lk_lpn = llpn;
    fill_en = fe; fill_super = fsup; fill_lpn = flpn; fill_ppn = fppn;
    purge_all = pa; purge_one = po; purge_super = psup; purge_lpn = plpn;
    ru = rwu; rs = rws;
    #1;
    fl = pa | rwu | rws;
    eh = exp_hit(lv, lsup, llpn, fl);
    chk(hit == eh, {req, " hit"}, hit, eh);
    chk(walk == (lv && !eh), {req, " walk_req"}, walk, lv && !eh);
    if (eh) chk(ppn == m_ppn[slot_of(lsup, llpn)], {req, " ppn"}, ppn, m_ppn[slot_of(lsup, llpn)]);
    if (fl) foreach (m_valid[i]) m_valid[i] = 0;
    else begin
      if (fe) begin
        m_valid[slot_of(fsup, flpn)] = 1;
        m_tag[slot_of(fsup, flpn)] = flpn[LPN_W-1:IDX_W];
      end
      if (po) m_valid[slot_of(psup, plpn)] = 0;
    end
    if (fe) m_ppn[slot_of(fsup, flpn)] = fppn;
    if (fe && !fl) m_tag[slot_of(fsup, flpn)] = flpn[LPN_W-1:IDX_W];
  endtask

  task automatic look(bit sup, logic [LPN_W-1:0] lpn, string req);
    cyc(1, sup, lpn, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic fill(bit sup, logic [LPN_W-1:0] lpn, logic [PPN_W-1:0] p);
    cyc(0, 0, 0, 1, sup, lpn, p, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    bit r_lv, r_ls, r_fe, r_fs, r_pa, r_po, r_ps, r_ru, r_rs;
    logic [LPN_W-1:0] r_ll, r_fl, r_pl;
    void'($urandom(32'h5eed));
    foreach (m_valid[i]) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) look(i[0], 8'(i * 37), "R1");
    // R5 idle lookup strobe
    cyc(0, 0, 8'h12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R6 fill and lookup in same cycle sees old contents
    cyc(1, 0, 8'h35, 1, 0, 8'h35, 12'habc, 0, 0, 0, 0, 0, 0, "R6");
    look(0, 8'h35, "R3");
    // R4 other mode misses
    look(1, 8'h35, "R4");
    fill(1, 8'h35, 12'h123);
    look(1, 8'h35, "R4");
    look(0, 8'h35, "R4");
    // R2 same slot, other tag replaces
    fill(0, 8'h75, 12'h777);
    look(0, 8'h35, "R2");
    look(0, 8'h75, "R2");
    // R9 selective purge by slot, regardless of tag
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 8'hf5, 0, 0, "R9");
    look(0, 8'h75, "R9");
    look(1, 8'h35, "R9");
    // R10 purge and fill on same slot, and on different slots
    cyc(0, 0, 0, 1, 0, 8'h21, 12'h321, 0, 1, 0, 8'h01, 0, 0, "R10");
    look(0, 8'h21, "R10");
    cyc(0, 0, 0, 1, 0, 8'h22, 12'h322, 0, 1, 1, 8'h35, 0, 0, "R10");
    look(0, 8'h22, "R10");
    look(1, 8'h35, "R10");
    // R7 purge all: same-cycle lookup misses, then all gone
    fill(1, 8'h44, 12'h444);
    cyc(1, 0, 8'h22, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
    look(0, 8'h22, "R7");
    look(1, 8'h44, "R7");
    // R11 flush discards a fill
    cyc(0, 0, 0, 1, 0, 8'h50, 12'h555, 1, 0, 0, 0, 0, 0, "R11");
    look(0, 8'h50, "R11");
    // R8 each root pointer write flushes
    fill(0, 8'h61, 12'h611);
    cyc(1, 0, 8'h61, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    look(0, 8'h61, "R8");
    fill(1, 8'h62, 12'h622);
    look(1, 8'h62, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    look(1, 8'h62, "R8");
    // random mix, R3
    for (int n = 0; n < 4000; n++) begin
      r_lv = ($urandom_range(0, 9) < 8); r_ls = $urandom_range(0, 1);
      r_ll = 8'($urandom_range(0, 63));
      r_fe = ($urandom_range(0, 9) < 3); r_fs = $urandom_range(0, 1);
      r_fl = 8'($urandom_range(0, 63));
      r_pa = ($urandom_range(0, 199) == 0);
      r_po = ($urandom_range(0, 19) == 0); r_ps = $urandom_range(0, 1);
      r_pl = 8'($urandom_range(0, 63));
      r_ru = ($urandom_range(0, 399) == 0); r_rs = ($urandom_range(0, 399) == 0);
      cyc(r_lv, r_ls, r_ll, r_fe, r_fs, r_fl, 12'($urandom), r_pa, r_po, r_ps, r_pl,
          r_ru, r_rs, "R3");
    end
    finish_run();
  end
endmodule